// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides which operating mode a small 8-bit controller core is in: running, idle, or powered down. Software requests a low-power mode by writing two request bits into a power-control register. The write strobe and bit values arrive here, and the chosen mode takes effect on the next clock. From the mode, the block drives three clock enables: one for the CPU, one for the peripherals and one for the oscillator. It also raises a one-cycle strobe that aborts an EEPROM write if a low-power mode is entered while that write is still in progress.

While a low-power mode is active, the block takes over the pads. The ALE and PSEN levels are forced. Each of the four ports gets a drive selection that depends on the mode and on whether program memory is on-chip or off-chip. Idle mode ends when any enabled interrupt is pending or on a hardware reset. Power-down ends only on a hardware reset. The reset pin is synchronized and then qualified by a run-length counter. The qualified reset is an output of the block and also returns the mode to running.

Top module: `lpm_ctrl`

## Requirements
- R1: After the synchronous reset, the mode reads 0 (run), all three clock enables are 1, `ee_abort` is 0, `hw_rst` is 0, `pad_force` is 0, ALE and PSEN levels read 1, and every port selection reads 0 (core-driven).
- R2: A write strobe with only the idle bit set, taken in run mode, makes the mode read 1 (idle) after that clock edge. In idle the CPU clock enable is 0, while the peripheral and oscillator enables stay 1.
- R3: A write strobe with the power-down bit set, taken in run mode, makes the mode read 2 (power-down) after that edge. In power-down all three clock enables are 0.
- R4: When both request bits are set in one write, the mode becomes power-down. When neither bit is set, the write leaves the mode in run.
- R5: In idle, a pending interrupt returns the mode to run at the next edge, which clears both request bits.
- R6: In power-down, a pending interrupt has no effect, and the mode and enables stay unchanged.
- R7: Write strobes taken while the mode is idle or power-down are ignored and produce no abort strobe.
- R8: `ee_abort` is high for exactly one cycle. That cycle is the first cycle of a low-power mode entered while `ee_busy` was high at the write. Otherwise `ee_abort` stays low.
- R9: In any low-power mode, `pad_force` is 1. ALE and PSEN are both 1 in idle and both 0 in power-down.
- R10: The port selection codes are 0 = core-driven, 1 = hold data latch, 2 = float, 3 = address. With internal program memory, all ports read 1 in both low-power modes. With external program memory, port 0 reads 2 in both modes, port 2 reads 3 in idle and 1 in power-down, and ports 1 and 3 read 1.
- R11: `hw_rst` rises only after `rst_pin` has been high for 24 consecutive synchronized cycles. Counting from the first edge that samples the pin high, that is the 26th edge (two synchronizer stages plus 24). A shorter high pulse has no effect.
- R12: While `hw_rst` is high, the mode is forced to run and write strobes are ignored. This holds from idle and from power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin | input | 1 | Asynchronous external reset pin |
| mode_wr | input | 1 | Power-control register write strobe |
| wr_idle | input | 1 | Idle request bit of the write |
| wr_pdown | input | 1 | Power-down request bit of the write |
| ee_busy | input | 1 | EEPROM write in progress |
| irq_pend | input | 1 | Any enabled interrupt pending |
| ext_prog | input | 1 | 1 = program memory is external |
| mode_st | output | 2 | 0 run, 1 idle, 2 power-down |
| hw_rst | output | 1 | Qualified hardware reset |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ee_abort | output | 1 | One-cycle EEPROM abort strobe |
| pad_force | output | 1 | Pads under low-power control |
| ale_lvl | output | 1 | Forced ALE level |
| psen_lvl | output | 1 | Forced PSEN level |
| p0_sel | output | 2 | Port 0 drive selection |
| p1_sel | output | 2 | Port 1 drive selection |
| p2_sel | output | 2 | Port 2 drive selection |
| p3_sel | output | 2 | Port 3 drive selection |

## Verification
The bench covers several corner cases:
- A write carrying both request bits. A design that honoured idle first would leave the oscillator running.
- An interrupt arriving during power-down. A design that let it wake the core would restart the oscillator.
- Port 2 with external program memory in both low-power modes. Swapping its address and latch choices shows up directly on the port selection.
- The reset pin held for exactly the qualifying length and for a shorter pulse. An off-by-one counter, or one that does not restart on a low pin, moves the edge where `hw_rst` rises.
- An abort strobe that lasts more than one cycle, or that fires on a write with no request bits.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int NPORT = 4;

    typedef enum logic [1:0] {
        LPM_RUN   = 2'd0,
        LPM_IDLE  = 2'd1,
        LPM_PDOWN = 2'd2
    } lpm_mode_e;

    typedef enum logic [1:0] {
        PAD_CORE  = 2'd0,
        PAD_LATCH = 2'd1,
        PAD_FLOAT = 2'd2,
        PAD_ADDR  = 2'd3
    } pad_sel_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } clk_en_t;

    typedef struct packed {
        logic                  force_en;
        logic                  ale;
        logic                  psen;
        logic [NPORT-1:0][1:0] sel;
    } pad_ctl_t;

    function automatic clk_en_t clk_en_for(lpm_mode_e m);
        clk_en_t c;
        case (m)
            LPM_IDLE:  c = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
            LPM_PDOWN: c = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
            default:   c = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
        endcase
        return c;
    endfunction

    function automatic pad_sel_e pad_sel_for(lpm_mode_e m, logic ext, int idx);
        pad_sel_e s;
        if (m == LPM_RUN)       s = PAD_CORE;
        else if (!ext)          s = PAD_LATCH;
        else if (idx == 0)      s = PAD_FLOAT;
        else if (idx == 2)      s = (m == LPM_IDLE) ? PAD_ADDR : PAD_LATCH;
        else                    s = PAD_LATCH;
        return s;
    endfunction

endpackage

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYC    = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic qual_rst
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(QUAL_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (rst || !sync_q[SYNC_STAGES-1]) run_cnt <= '0;
        else if (run_cnt != CMAX)          run_cnt <= run_cnt + 1'b1;
    end

    assign qual_rst = (run_cnt == CMAX);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hw_rst,
    input  logic      mode_wr,
    input  logic      wr_idle,
    input  logic      wr_pdown,
    input  logic      ee_busy,
    input  logic      irq_pend,
    output lpm_mode_e mode,
    output logic      ee_abort
);
    lpm_mode_e mode_nx;
    logic      enter_lp;

    assign enter_lp = (mode == LPM_RUN) && mode_wr && (wr_idle || wr_pdown);

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            LPM_RUN: begin
                if (mode_wr && wr_pdown)     mode_nx = LPM_PDOWN;
                else if (mode_wr && wr_idle) mode_nx = LPM_IDLE;
            end
            LPM_IDLE:  if (irq_pend) mode_nx = LPM_RUN;
            LPM_PDOWN: mode_nx = LPM_PDOWN;
            default:   mode_nx = LPM_RUN;
        endcase
        if (hw_rst) mode_nx = LPM_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= LPM_RUN;
            ee_abort <= 1'b0;
        end else begin
            mode     <= mode_nx;
            ee_abort <= enter_lp && ee_busy && !hw_rst;
        end
    end
endmodule

// File: rtl/lpm_pad_map.sv
module lpm_pad_map
    import lpm_pkg::*;
(
    input  lpm_mode_e mode,
    input  logic      ext_prog,
    output pad_ctl_t  pads
);
    assign pads.force_en = (mode != LPM_RUN);
    assign pads.ale      = (mode != LPM_PDOWN);
    assign pads.psen     = (mode != LPM_PDOWN);

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        assign pads.sel[i] = pad_sel_for(mode, ext_prog, i);
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYC    = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_pin,
    input  logic       mode_wr,
    input  logic       wr_idle,
    input  logic       wr_pdown,
    input  logic       ee_busy,
    input  logic       irq_pend,
    input  logic       ext_prog,
    output logic [1:0] mode_st,
    output logic       hw_rst,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       ee_abort,
    output logic       pad_force,
    output logic       ale_lvl,
    output logic       psen_lvl,
    output logic [1:0] p0_sel,
    output logic [1:0] p1_sel,
    output logic [1:0] p2_sel,
    output logic [1:0] p3_sel
);
    lpm_mode_e mode;
    clk_en_t   cen;
    pad_ctl_t  pads;

    lpm_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYC(QUAL_CYC)) u_qual (
        .clk(clk), .rst(rst), .pin(rst_pin), .qual_rst(hw_rst)
    );

    lpm_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .hw_rst(hw_rst), .mode_wr(mode_wr),
        .wr_idle(wr_idle), .wr_pdown(wr_pdown), .ee_busy(ee_busy),
        .irq_pend(irq_pend), .mode(mode), .ee_abort(ee_abort)
    );

    lpm_pad_map u_pad (.mode(mode), .ext_prog(ext_prog), .pads(pads));

    assign cen        = clk_en_for(mode);
    assign mode_st    = mode;
    assign cpu_clk_en = cen.cpu;
    assign per_clk_en = cen.per;
    assign osc_en     = cen.osc;
    assign pad_force  = pads.force_en;
    assign ale_lvl    = pads.ale;
    assign psen_lvl   = pads.psen;
    assign p0_sel     = pads.sel[0];
    assign p1_sel     = pads.sel[1];
    assign p2_sel     = pads.sel[2];
    assign p3_sel     = pads.sel[3];
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       rst_pin,
    input logic       irq_pend,
    input logic       mode_wr,
    input logic [1:0] mode_st,
    input logic       hw_rst,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic       ee_abort,
    input logic       pad_force,
    input logic       ale_lvl,
    input logic       psen_lvl
);
    a_r2_idle_clocks: assert property (@(posedge clk) disable iff (rst)
        (mode_st == 2'd1) |-> (!cpu_clk_en && per_clk_en && osc_en));

    a_r3_pdown_clocks: assert property (@(posedge clk) disable iff (rst)
        (mode_st == 2'd2) |-> (!cpu_clk_en && !per_clk_en && !osc_en));

    a_r5_idle_wake: assert property (@(posedge clk) disable iff (rst)
        (mode_st == 2'd1 && irq_pend) |=> (mode_st == 2'd0));

    a_r6_pdown_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_st == 2'd2 && !hw_rst) |=> (mode_st == 2'd2));

    a_r7_no_write_in_lp: assert property (@(posedge clk) disable iff (rst)
        (mode_st == 2'd1 && mode_wr && !irq_pend && !hw_rst) |=> (mode_st == 2'd1));

    a_r8_abort_single: assert property (@(posedge clk) disable iff (rst)
        ee_abort |=> !ee_abort);

    a_r8_abort_on_entry: assert property (@(posedge clk) disable iff (rst)
        ee_abort |-> (mode_st != 2'd0 && $past(mode_st) == 2'd0));

    a_r9_pad_levels: assert property (@(posedge clk) disable iff (rst)
        pad_force |-> (ale_lvl == psen_lvl && ale_lvl == (mode_st == 2'd1)));

    a_r11_pin_held: assert property (@(posedge clk) disable iff (rst)
        $rose(hw_rst) |-> ($past(rst_pin, 2) && $past(rst_pin, 3)));

    a_r12_reset_to_run: assert property (@(posedge clk) disable iff (rst)
        hw_rst |=> (mode_st == 2'd0));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .rst_pin(rst_pin), .irq_pend(irq_pend),
    .mode_wr(mode_wr), .mode_st(mode_st), .hw_rst(hw_rst),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .ee_abort(ee_abort), .pad_force(pad_force), .ale_lvl(ale_lvl),
    .psen_lvl(psen_lvl)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pin = 0, mode_wr = 0, wr_idle = 0, wr_pdown = 0;
    logic ee_busy = 0, irq_pend = 0, ext_prog = 0;
    logic [1:0] mode_st, p0_sel, p1_sel, p2_sel, p3_sel;
    logic hw_rst, cpu_clk_en, per_clk_en, osc_en, ee_abort;
    logic pad_force, ale_lvl, psen_lvl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lpm_ctrl u_lpm_ctrl (.*);

    // {idle,pdown,ext,busy}, mode, {cpu,per,osc}, abort, {force,ale,psen}, {p0,p1,p2,p3}
    localparam logic [20:0] VEC [0:7] = '{
        {4'b1000, 2'd1, 3'b011, 1'b0, 3'b111, 8'b01_01_01_01},
        {4'b1011, 2'd1, 3'b011, 1'b1, 3'b111, 8'b10_01_11_01},
        {4'b0100, 2'd2, 3'b000, 1'b0, 3'b100, 8'b01_01_01_01},
        {4'b0111, 2'd2, 3'b000, 1'b1, 3'b100, 8'b10_01_01_01},
        {4'b1110, 2'd2, 3'b000, 1'b0, 3'b100, 8'b10_01_01_01},
        {4'b0001, 2'd0, 3'b111, 1'b0, 3'b011, 8'b00_00_00_00},
        {4'b1010, 2'd1, 3'b011, 1'b0, 3'b111, 8'b10_01_11_01},
        {4'b1101, 2'd2, 3'b000, 1'b1, 3'b100, 8'b01_01_01_01}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_mode(input logic i, input logic p, input logic busy);
        mode_wr = 1; wr_idle = i; wr_pdown = p; ee_busy = busy;
        step(1);
        mode_wr = 0; wr_idle = 0; wr_pdown = 0; ee_busy = 0;
    endtask

    task automatic pin_reset();
        rst_pin = 1;
        step(30);
        check("R12 hw_rst during long pin", hw_rst, 1);
        check("R12 mode forced run", mode_st, 0);
        rst_pin = 0;
        step(4);
        check("R12 hw_rst released", hw_rst, 0);
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        // R1 reset state
        check("R1 mode", mode_st, 0);
        check("R1 clocks", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
        check("R1 abort/hw_rst", {ee_abort, hw_rst}, 0);
        check("R1 pad force/ale/psen", {pad_force, ale_lvl, psen_lvl}, 3'b011);
        check("R1 ports", {p0_sel, p1_sel, p2_sel, p3_sel}, 0);

        for (int v = 0; v < 8; v++) begin
            logic [20:0] e;
            e = VEC[v];
            ext_prog = e[18];
            write_mode(e[20], e[19], e[17]);
            // R2 / R3 / R4 mode selection
            check($sformatf("R4 mode vec%0d", v), mode_st, e[16:15]);
            check($sformatf("R3 clocks vec%0d", v), {cpu_clk_en, per_clk_en, osc_en}, e[14:12]);
            check($sformatf("R8 abort vec%0d", v), ee_abort, e[11]);
            check($sformatf("R9 pads vec%0d", v), {pad_force, ale_lvl, psen_lvl}, e[10:8]);
            check($sformatf("R10 ports vec%0d", v), {p0_sel, p1_sel, p2_sel, p3_sel}, e[7:0]);
            step(1);
            check($sformatf("R8 abort one cycle vec%0d", v), ee_abort, 0);
            if (e[16:15] == 2'd1) begin
                irq_pend = 1; step(1); irq_pend = 0;
                check($sformatf("R5 irq wakes idle vec%0d", v), mode_st, 0);
            end else if (e[16:15] == 2'd2) begin
                irq_pend = 1; step(2); irq_pend = 0;
                check($sformatf("R6 irq ignored vec%0d", v), mode_st, 2);
                check($sformatf("R6 osc off vec%0d", v), osc_en, 0);
                pin_reset();
            end
        end

        // R7: write in idle ignored
        ext_prog = 0;
        write_mode(1, 0, 0);
        write_mode(0, 1, 1);
        check("R7 mode stays idle", mode_st, 1);
        check("R7 no abort", ee_abort, 0);

        // R11: short pulse ignored
        rst_pin = 1; step(20); rst_pin = 0;
        begin
            int seen = 0;
            for (int k = 0; k < 6; k++) begin
                if (hw_rst) seen = 1;
                step(1);
            end
            check("R11 short pulse no reset", seen, 0);
        end
        check("R11 idle kept after short pulse", mode_st, 1);

        // R11: exact qualification edge
        rst_pin = 1;
        step(25);
        check("R11 not yet at edge 25", hw_rst, 0);
        check("R11 still idle at edge 25", mode_st, 1);
        step(1);
        check("R11 asserted at edge 26", hw_rst, 1);
        // R12: write ignored while hw_rst
        write_mode(0, 1, 1);
        check("R12 write ignored in reset", mode_st, 0);
        check("R12 no abort in reset", ee_abort, 0);
        rst_pin = 0;
        step(4);
        check("R12 run after release", mode_st, 0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        done = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule